// File: doc/BRIEF.md
# Two-Stage Reboot Watchdog Timer

This block is a host-programmable watchdog for a chipset. Software programs a 6-bit reload value in coarse ticks (one tick is a parameterised number of input clocks, nominally 0.6 s), clears a halt bit to start the countdown, and must then keep writing a kick code to hold the counter away from zero. A timeout of S seconds corresponds to a reload value of (S*10)/6 ticks. Reload values below 4 are rejected by the hardware, and the previous value stays in effect.

When the counter runs out the first time, the block records a first-stage flag, can raise a one-cycle interrupt pulse if that is enabled, and counts the same period again. If the counter runs out a second time with no kick in between, a sticky second-stage flag is set and a system reset request is raised. The reset request only goes out while an external reboot-permission input is high. Software clears both flags by writing ones to the status register.

Access goes through a simple byte-wide register port in a 16-byte window. The four registers sit on 4-byte aligned offsets: 0x0 holds the kick code and the live count, 0x4 holds status, 0x8 holds control, and 0xC holds the timer setting.

Top module: `chip_wdt`

## Requirements
- R1: After reset the halt bit (control bit 0) reads 1, the interrupt enable (control bit 1) reads 0, status reads 0x00, the timer register at 0xC reads the RESET_RELOAD value (default 50) with upper bits 0, the count reads the same value, and smi_irq and rst_req are low.
- R2: A write to offset 0xC always stores bits 7:6, which read back unchanged. It stores bits 5:0 as the reload value only when they are 4 or more; a value from 0 to 3 leaves the previous reload value in place.
- R3: Writing 0x01 to offset 0x0 loads the counter from the reload value and clears the first-stage flag (status bit 0). Any other value written there has no effect.
- R4: While control bit 0 (halt) is 1, the count holds. Once halt is cleared, the count drops by one every PRESCALE clock cycles.
- R5: With reload value N, the first expiry comes (N+1)*PRESCALE cycles after counting starts from a fresh load. It sets status bit 0 and reloads the counter to N.
- R6: At the first expiry, smi_irq pulses high for exactly one cycle when control bit 1 is set. It stays low when that bit is clear.
- R7: A second expiry, with no kick since the first, sets status bit 1 (sticky) and raises rst_req if reboot_ok is high in that cycle.
- R8: If reboot_ok is low at the second expiry, status bit 1 is still set but rst_req stays low.
- R9: Writing to offset 0x4 clears each status bit written as 1 and leaves bits written as 0 untouched. Clearing bit 1 also drops rst_req.
- R10: A read of offset 0x0 returns the live count in bits 5:0. Reads are combinational from bus_addr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Byte offset in the window; only aligned offsets decode |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| reboot_ok | input | 1 | External permission for the reset request |
| smi_irq | output | 1 | One-cycle interrupt pulse at the first expiry |
| rst_req | output | 1 | Reset request after the second expiry |

## Verification
The hardest state to reach from the ports is the second expiry. It needs two full countdown periods with no kick in between and the first-stage flag still set. The reset request then depends on the permission input in that exact cycle. The bench uses a short prescaler and starts the countdown by clearing the halt bit after a kick. From that edge it counts clock cycles, so it can sample status, the interrupt and the reset request one cycle before each expiry and in the cycle of the expiry itself. It then repeats the double expiry with permission withdrawn, and with a kick placed between the two expiries.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned DW        = 8;
  localparam int unsigned AW        = 4;
  localparam int unsigned CW        = 6;
  localparam int unsigned MIN_LOAD  = 4;
  localparam logic [DW-1:0] KICK_CODE = 8'h01;

  typedef enum logic [1:0] {
    SLOT_COUNT = 2'd0,
    SLOT_STAT  = 2'd1,
    SLOT_CTRL  = 2'd2,
    SLOT_TMR   = 2'd3
  } slot_e;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_n_sync = sh_q[1];
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned PRESCALE = 20_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic          at_last;

  assign at_last = (pre_q == LAST);
  assign tick    = run && !restart && at_last;

  always_comb begin
    pre_d = pre_q;
    if (restart)      pre_d = '0;
    else if (run)     pre_d = at_last ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned RESET_RELOAD = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [CW-1:0] count,
  input  logic [1:0]    sts,
  output logic          halt,
  output logic          ie,
  output logic [CW-1:0] reload,
  output logic          kick,
  output logic [1:0]    sts_clr
);
  localparam int unsigned XW = DW - CW;

  logic          aligned;
  slot_e         slot;
  logic          halt_q, halt_d, ie_q, ie_d;
  logic [CW-1:0] reload_q, reload_d;
  logic [XW-1:0] spare_q, spare_d;
  logic          wr_ctrl, wr_tmr, wr_stat, wr_cnt;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign slot    = slot_e'(bus_addr[3:2]);
  assign wr_cnt  = bus_wr && aligned && (slot == SLOT_COUNT);
  assign wr_stat = bus_wr && aligned && (slot == SLOT_STAT);
  assign wr_ctrl = bus_wr && aligned && (slot == SLOT_CTRL);
  assign wr_tmr  = bus_wr && aligned && (slot == SLOT_TMR);

  assign kick    = wr_cnt && (bus_wdata == KICK_CODE);
  assign sts_clr = wr_stat ? bus_wdata[1:0] : 2'b00;

  always_comb begin
    halt_d   = halt_q;
    ie_d     = ie_q;
    reload_d = reload_q;
    spare_d  = spare_q;
    if (wr_ctrl) begin
      halt_d = bus_wdata[0];
      ie_d   = bus_wdata[1];
    end
    if (wr_tmr) begin
      spare_d = bus_wdata[DW-1:CW];
      if (bus_wdata[CW-1:0] >= CW'(MIN_LOAD)) reload_d = bus_wdata[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q   <= 1'b1;
      ie_q     <= 1'b0;
      reload_q <= CW'(RESET_RELOAD);
      spare_q  <= '0;
    end else begin
      halt_q   <= halt_d;
      ie_q     <= ie_d;
      reload_q <= reload_d;
      spare_q  <= spare_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      unique case (slot)
        SLOT_COUNT: bus_rdata = {{XW{1'b0}}, count};
        SLOT_STAT:  bus_rdata = {{(DW-2){1'b0}}, sts};
        SLOT_CTRL:  bus_rdata = {{(DW-2){1'b0}}, ie_q, halt_q};
        SLOT_TMR:   bus_rdata = {spare_q, reload_q};
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign halt   = halt_q;
  assign ie     = ie_q;
  assign reload = reload_q;
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int unsigned RESET_RELOAD = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          kick,
  input  logic [CW-1:0] reload,
  input  logic [1:0]    sts_clr,
  input  logic          ie,
  input  logic          reboot_ok,
  output logic [CW-1:0] count,
  output logic [1:0]    sts,
  output logic          smi_irq,
  output logic          rst_req
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          first_q, first_d, second_q, second_d;
  logic          smi_q, smi_d, rst_q, rst_d;

  always_comb begin
    cnt_d    = cnt_q;
    first_d  = first_q;
    second_d = second_q;
    smi_d    = 1'b0;
    rst_d    = rst_q;
    if (sts_clr[0]) first_d = 1'b0;
    if (sts_clr[1]) begin
      second_d = 1'b0;
      rst_d    = 1'b0;
    end
    if (kick) begin
      cnt_d   = reload;
      first_d = 1'b0;
    end else if (tick) begin
      if (cnt_q == '0) begin
        cnt_d = reload;
        if (!first_q) begin
          first_d = 1'b1;
          smi_d   = ie;
        end else begin
          second_d = 1'b1;
          if (reboot_ok) rst_d = 1'b1;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= CW'(RESET_RELOAD);
      first_q  <= 1'b0;
      second_q <= 1'b0;
      smi_q    <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      first_q  <= first_d;
      second_q <= second_d;
      smi_q    <= smi_d;
      rst_q    <= rst_d;
    end
  end

  assign count   = cnt_q;
  assign sts     = {second_q, first_q};
  assign smi_irq = smi_q;
  assign rst_req = rst_q;
endmodule

// File: rtl/chip_wdt.sv
module chip_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned PRESCALE     = 20_000_000,
  parameter int unsigned RESET_RELOAD = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [3:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       reboot_ok,
  output logic       smi_irq,
  output logic       rst_req
);
  logic          srst_n;
  logic          tick, kick_stb, ctl_halt, ctl_ie;
  logic [CW-1:0] cnt_val, reload_val;
  logic [1:0]    sts_val, sts_clr;

  wdt_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(srst_n));

  wdt_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst_n(srst_n), .run(!ctl_halt), .restart(kick_stb), .tick(tick)
  );

  wdt_regs #(.RESET_RELOAD(RESET_RELOAD)) u_regs (
    .clk(clk), .rst_n(srst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .count(cnt_val),
    .sts(sts_val), .halt(ctl_halt), .ie(ctl_ie), .reload(reload_val),
    .kick(kick_stb), .sts_clr(sts_clr)
  );

  wdt_core #(.RESET_RELOAD(RESET_RELOAD)) u_core (
    .clk(clk), .rst_n(srst_n), .tick(tick), .kick(kick_stb),
    .reload(reload_val), .sts_clr(sts_clr), .ie(ctl_ie),
    .reboot_ok(reboot_ok), .count(cnt_val), .sts(sts_val),
    .smi_irq(smi_irq), .rst_req(rst_req)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       smi_irq,
  input logic       rst_req,
  input logic       reboot_ok,
  input logic       ie,
  input logic       halt,
  input logic       kick,
  input logic [5:0] count,
  input logic [5:0] reload,
  input logic [1:0] sts
);
  // R6: interrupt is a single-cycle pulse
  a_r6_smi_single: assert property (@(posedge clk) disable iff (!rst_n)
    smi_irq |=> !smi_irq);

  // R6: interrupt only when enabled in the cycle before
  a_r6_smi_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    smi_irq |-> $past(ie));

  // R8: reset request only rises with permission present
  a_r8_rst_needs_perm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(reboot_ok));

  // R7: reset request implies second-stage status
  a_r7_rst_has_status: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> sts[1]);

  // R4: count holds while halted and not kicked
  a_r4_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(halt) && !$past(kick)) |-> $stable(count));

  // R2: reload value never below the minimum
  a_r2_reload_min: assert property (@(posedge clk) disable iff (!rst_n)
    reload >= 6'd4);
endmodule

bind chip_wdt wdt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .smi_irq(smi_irq), .rst_req(rst_req),
  .reboot_ok(reboot_ok), .ie(ctl_ie), .halt(ctl_halt), .kick(kick_stb),
  .count(cnt_val), .reload(reload_val), .sts(sts_val)
);

// File: tb/sim_chip_wdt.sv
`timescale 1ns/1ps
module sim_chip_wdt;
  localparam int unsigned P = 4;

  logic       clk;
  logic       rst_n;
  logic       bus_wr;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       reboot_ok;
  logic       smi_irq;
  logic       rst_req;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int smi_seen = 0;

  chip_wdt #(.PRESCALE(P), .RESET_RELOAD(50)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .reboot_ok(reboot_ok),
    .smi_irq(smi_irq), .rst_req(rst_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (smi_irq) smi_seen <= smi_seen + 1;
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 100000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // timer register walk: {write data, expected read-back}
  localparam logic [15:0] TMR_VEC [8] = '{
    {8'h8A, 8'h8A}, {8'h42, 8'h4A}, {8'h03, 8'h0A}, {8'h04, 8'h04},
    {8'hFF, 8'hFF}, {8'h00, 8'h3F}, {8'hC1, 8'hFF}, {8'h07, 8'h07}
  };

  logic [7:0] v;
  int base;

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 4'h0; bus_wdata = 8'h00; reboot_ok = 1'b1;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd(4'h4, v); chk("R1 status", v, 8'h00);
    rd(4'h8, v); chk("R1 control", v, 8'h01);
    rd(4'hC, v); chk("R1 timer", v, 8'h32);
    rd(4'h0, v); chk("R1 count", v, 8'h32);
    chk("R1 smi", smi_irq, 0);
    chk("R1 rst", rst_req, 0);

    // R2 vector walk
    for (int i = 0; i < 8; i++) begin
      wr(4'hC, TMR_VEC[i][15:8]);
      rd(4'hC, v); chk("R2 timer readback", v, TMR_VEC[i][7:0]);
    end

    // R4 halted count holds (no kick yet, count still reset value)
    idle(30);
    rd(4'h0, v); chk("R4 halted count", v, 8'h32);

    // R3 kick loads reload=4, other code no effect
    wr(4'hC, 8'h04);
    wr(4'h0, 8'h01);
    rd(4'h0, v); chk("R3 kick loads", v, 8'h04);
    wr(4'hC, 8'h09);
    wr(4'h0, 8'h02);
    rd(4'h0, v); chk("R3 non-kick code ignored", v, 8'h04);
    wr(4'hC, 8'h04);

    // R4/R5/R6/R7 precise timeline with ie=1, permission on
    base = smi_seen;
    wr(4'h8, 8'h02);
    idle(3);
    rd(4'h0, v); chk("R4 before first tick", v, 8'h04);
    idle(1);
    rd(4'h0, v); chk("R10 count after one tick", v, 8'h03);
    idle(15);
    rd(4'h4, v); chk("R5 no expiry yet", v, 8'h00);
    chk("R6 smi low before expiry", smi_irq, 0);
    idle(1);
    rd(4'h4, v); chk("R5 first expiry flag", v, 8'h01);
    rd(4'h0, v); chk("R5 reload on expiry", v, 8'h04);
    chk("R6 smi pulse", smi_irq, 1);
    idle(1);
    chk("R6 smi one cycle", smi_irq, 0);
    idle(18);
    chk("R7 no reset before second expiry", rst_req, 0);
    idle(1);
    rd(4'h4, v); chk("R7 second flag", v, 8'h03);
    chk("R7 reset request", rst_req, 1);
    chk("R6 pulse count", smi_seen - base, 1);

    // R9 write-one-to-clear
    wr(4'h4, 8'h01);
    rd(4'h4, v); chk("R9 clear bit0 only", v, 8'h02);
    chk("R9 rst held", rst_req, 1);
    wr(4'h4, 8'h02);
    rd(4'h4, v); chk("R9 clear bit1", v, 8'h00);
    chk("R9 rst dropped", rst_req, 0);

    // R8 permission withheld, ie=0
    wr(4'h8, 8'h01);
    reboot_ok = 1'b0;
    wr(4'h0, 8'h01);
    wr(4'h4, 8'h03);
    base = smi_seen;
    wr(4'h8, 8'h00);
    idle(45);
    rd(4'h4, v); chk("R8 second flag without permission", v, 8'h03);
    chk("R8 no reset request", rst_req, 0);
    chk("R6 no smi when disabled", smi_seen - base, 0);

    // R3 kick between expiries prevents second stage
    wr(4'h8, 8'h01);
    reboot_ok = 1'b1;
    wr(4'h4, 8'h03);
    wr(4'h0, 8'h01);
    wr(4'h8, 8'h00);
    idle(22);
    rd(4'h4, v); chk("R3 first expiry seen", v, 8'h01);
    wr(4'h0, 8'h01);
    rd(4'h4, v); chk("R3 kick clears first flag", v, 8'h00);
    idle(22);
    rd(4'h4, v); chk("R3 only first stage again", v, 8'h01);
    chk("R3 no reset after kick", rst_req, 0);

    // R3 periodic kicks keep status clear
    wr(4'h0, 8'h01);
    wr(4'h4, 8'h03);
    for (int k = 0; k < 10; k++) begin
      idle(8);
      wr(4'h0, 8'h01);
    end
    rd(4'h4, v); chk("R3 kicked never expires", v, 8'h00);

    // R4 halt mid-count
    wr(4'h8, 8'h01);
    rd(4'h0, v); base = v;
    idle(25);
    rd(4'h0, v); chk("R4 halt freezes count", v, base);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule